// File: doc/BRIEF.md
# Grouped Fixed-Priority Channel Arbiter

This block chooses which of up to 32 DMA channels may use a shared bus. Each channel raises a request bit. The arbiter registers one winner and presents it in two forms: a one-hot grant vector and a binary channel index. A valid flag marks that the grant is live. The bus side answers with a single-cycle accept pulse. Until that pulse arrives, the winner stays on the outputs.

The priority of a channel is fixed by its index. Index bits 3:2 give one of four levels, and level 0 is the most urgent. Because only those two bits count, each level holds two separate runs of four channels, one in the lower sixteen indices and one in the upper sixteen. The eight channels that share a level take turns. A per-level pointer moves past a channel only when that channel's grant is accepted.

A parameter sets how many channels exist. Any request bit at or above that count plays no part in arbitration.

Top module: `grp_chan_arbiter`

## Requirements
- R1: While reset is held and on the first cycle after it, the valid flag is 0, the grant vector is all zeros and the index is 0.
- R2: When a new winner is due and no implemented channel requests, the next cycle shows valid 0, an all-zero grant and index 0.
- R3: The level of channel i is bits 3:2 of i, and level 0 is the highest. A request at a more urgent level always beats requests at less urgent levels in the same choice.
- R4: Channels i and i+16 (for i below 16) share one level and compete as equals, for example channels 0-3 and 16-19 at level 0.
- R5: Within a level, members are visited in the cyclic order L*4+0..3, then 16+L*4+0..3. On an accept, that level's pointer moves to the member just after the accepted one.
- R6: A level's pointer does not move unless a grant at that level is accepted.
- R7: While valid is 1 and accept is 0, the grant, the index and valid hold their values at the next edge, whatever the requests do.
- R8: Request bits at indices equal to or above NUM_CH never produce a grant.
- R9: The grant vector is zero or one-hot. Valid equals the OR of the grant bits, and when valid is 1 the grant bit at the index is set.
- R10: A new choice is made at a clock edge where valid is 0 or accept is 1. It uses the request vector of that cycle and appears on the outputs after the edge. An accept and a fresh choice can happen at the same edge.
- R11: The accept input has no effect while valid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 32 | Request bit per channel |
| ack_i | input | 1 | Grant-accepted pulse from the bus side |
| gnt_o | output | 32 | One-hot grant |
| gnt_idx_o | output | 5 | Index of the granted channel |
| gnt_valid_o | output | 1 | Grant is live |

## Verification
The bench sets a level-0 request in the upper group against a level-3 request. An arbiter that used plain low-index priority, or all index bits, would pick the wrong one. It changes requests while a grant is outstanding, so a design that re-arbitrated would switch the winner before the accept. It cycles a full level with accepts on every cycle, which exposes a pointer that wraps inside only the lower group or advances without an accept. It also sends upper-channel requests to a 20-channel instance, which would grant channels that do not exist if the masking were missing.

// File: rtl/grp_arb_pkg.sv
package grp_arb_pkg;
    localparam int CH_MAX  = 32;
    localparam int LEVELS  = 4;
    localparam int MEMBERS = 8;
    localparam int IDX_W   = $clog2(CH_MAX);
    localparam int PTR_W   = $clog2(MEMBERS);
    localparam int LVL_W   = $clog2(LEVELS);

    typedef struct packed {
        logic                          valid;
        logic [IDX_W-1:0]              idx;
        logic [CH_MAX-1:0]             grant;
        logic [LEVELS-1:0][PTR_W-1:0]  ptr;
    } arb_state_t;

    // channel index from level and member position inside the level
    function automatic logic [IDX_W-1:0] chan_of(input logic [LVL_W-1:0] lvl,
                                                 input logic [PTR_W-1:0] mem);
        return {mem[2], lvl, mem[1:0]};
    endfunction
endpackage

// File: rtl/grp_req_mask.sv
module grp_req_mask
    import grp_arb_pkg::*;
#(
    parameter int NUM_CH = 32
) (
    input  logic [CH_MAX-1:0]               req_i,
    output logic [LEVELS-1:0][MEMBERS-1:0]  lvl_req_o
);
    for (genvar gl = 0; gl < LEVELS; gl++) begin : g_lvl
        for (genvar gm = 0; gm < MEMBERS; gm++) begin : g_mem
            localparam int CH = int'(chan_of(LVL_W'(gl), PTR_W'(gm)));
            if (CH < NUM_CH) begin : g_live
                assign lvl_req_o[gl][gm] = req_i[CH];
            end else begin : g_dead
                assign lvl_req_o[gl][gm] = 1'b0;
            end
        end
    end
endmodule

// File: rtl/grp_rr_pick8.sv
module grp_rr_pick8
    import grp_arb_pkg::*;
(
    input  logic [MEMBERS-1:0] req_i,
    input  logic [PTR_W-1:0]   ptr_i,
    output logic               hit_o,
    output logic [PTR_W-1:0]   mem_o
);
    always_comb begin
        logic [PTR_W-1:0] pos;
        hit_o = 1'b0;
        mem_o = '0;
        // descending scan so the smallest offset from the pointer wins
        for (int k = MEMBERS - 1; k >= 0; k--) begin
            pos = ptr_i + PTR_W'(k);
            if (req_i[pos]) begin
                hit_o = 1'b1;
                mem_o = pos;
            end
        end
    end
endmodule

// File: rtl/grp_level_sel.sv
module grp_level_sel
    import grp_arb_pkg::*;
(
    input  logic [LEVELS-1:0]             hit_i,
    input  logic [LEVELS-1:0][PTR_W-1:0]  mem_i,
    output logic                          any_o,
    output logic [IDX_W-1:0]              idx_o
);
    always_comb begin
        any_o = 1'b0;
        idx_o = '0;
        // least urgent first, so level 0 overwrites last
        for (int l = LEVELS - 1; l >= 0; l--) begin
            if (hit_i[l]) begin
                any_o = 1'b1;
                idx_o = chan_of(LVL_W'(l), mem_i[l]);
            end
        end
    end
endmodule

// File: rtl/grp_chan_arbiter.sv
module grp_chan_arbiter
    import grp_arb_pkg::*;
#(
    parameter int NUM_CH = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CH_MAX-1:0] req_i,
    input  logic              ack_i,
    output logic [CH_MAX-1:0] gnt_o,
    output logic [IDX_W-1:0]  gnt_idx_o,
    output logic              gnt_valid_o
);
    arb_state_t st_d, st_q;

    logic [LEVELS-1:0][MEMBERS-1:0] lvl_req;
    logic [LEVELS-1:0][PTR_W-1:0]   ptr_nx;
    logic [LEVELS-1:0][PTR_W-1:0]   lvl_mem;
    logic [LEVELS-1:0]              lvl_hit;
    logic                           sel_any;
    logic [IDX_W-1:0]               sel_idx;
    logic                           acc_ok;

    grp_req_mask #(.NUM_CH(NUM_CH)) u_mask (
        .req_i     (req_i),
        .lvl_req_o (lvl_req)
    );

    // pointer as it stands after this cycle's accept
    always_comb begin
        acc_ok = st_q.valid & ack_i;
        ptr_nx = st_q.ptr;
        if (acc_ok) begin
            ptr_nx[st_q.idx[3:2]] = {st_q.idx[4], st_q.idx[1:0]} + PTR_W'(1);
        end
    end

    for (genvar gl = 0; gl < LEVELS; gl++) begin : g_pick
        grp_rr_pick8 u_pick (
            .req_i (lvl_req[gl]),
            .ptr_i (ptr_nx[gl]),
            .hit_o (lvl_hit[gl]),
            .mem_o (lvl_mem[gl])
        );
    end

    grp_level_sel u_sel (
        .hit_i (lvl_hit),
        .mem_i (lvl_mem),
        .any_o (sel_any),
        .idx_o (sel_idx)
    );

    always_comb begin
        st_d     = st_q;
        st_d.ptr = ptr_nx;
        if (!st_q.valid || acc_ok) begin
            st_d.valid = sel_any;
            st_d.idx   = sel_any ? sel_idx : '0;
            st_d.grant = sel_any ? (CH_MAX'(1) << sel_idx) : '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign gnt_o       = st_q.grant;
    assign gnt_idx_o   = st_q.idx;
    assign gnt_valid_o = st_q.valid;
endmodule

// File: rtl/grp_arb_checker.sv
module grp_arb_checker
    import grp_arb_pkg::*;
#(
    parameter int NUM_CH = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [CH_MAX-1:0] req_i,
    input logic              ack_i,
    input logic [CH_MAX-1:0] gnt_o,
    input logic [IDX_W-1:0]  gnt_idx_o,
    input logic              gnt_valid_o
);
    localparam logic [CH_MAX-1:0] LIVE_MASK =
        (NUM_CH >= CH_MAX) ? '1 : ((CH_MAX'(1) << NUM_CH) - CH_MAX'(1));
    localparam logic [CH_MAX-1:0] LVL0_MASK = 32'h000F_000F;

    logic choose;
    assign choose = !gnt_valid_o || ack_i;

    AST_GNT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt_o)); // R9
    AST_VALID_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        gnt_valid_o == (|gnt_o)); // R9
    AST_IDX_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        gnt_valid_o |-> gnt_o[gnt_idx_o]); // R9
    AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_valid_o && !ack_i) |=> ($stable(gnt_o) && $stable(gnt_idx_o) && gnt_valid_o)); // R7
    AST_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        gnt_valid_o |-> (int'(gnt_idx_o) < NUM_CH)); // R8
    AST_FROM_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        choose |=> (!gnt_valid_o || (|(gnt_o & $past(req_i))))); // R10
    AST_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (choose && ((req_i & LIVE_MASK) == '0)) |=> !gnt_valid_o); // R2
    AST_LEVEL0_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (choose && ((req_i & LIVE_MASK & LVL0_MASK) != '0)) |=> (gnt_idx_o[3:2] == 2'd0)); // R3
endmodule

bind grp_chan_arbiter grp_arb_checker #(.NUM_CH(NUM_CH)) u_chk (.*);

// File: tb/test_grp_chan_arbiter.sv
module test_grp_chan_arbiter;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] req = '0;
    logic        ack_a = 1'b0, ack_b = 1'b0;
    logic [31:0] gnt_a, gnt_b;
    logic [4:0]  idx_a, idx_b;
    logic        val_a, val_b;

    int n_checks = 0;
    int n_fails  = 0;

    // model state per instance
    bit          mv_a = 0, mv_b = 0;
    int          mi_a = 0, mi_b = 0;
    logic [11:0] mp_a = '0, mp_b = '0;

    always #4ns clk = ~clk;

    grp_chan_arbiter #(.NUM_CH(32)) i_grp_chan_arbiter (
        .clk(clk), .rst_n(rst_n), .req_i(req), .ack_i(ack_a),
        .gnt_o(gnt_a), .gnt_idx_o(idx_a), .gnt_valid_o(val_a));

    grp_chan_arbiter #(.NUM_CH(20)) i_grp_chan_arbiter_small (
        .clk(clk), .rst_n(rst_n), .req_i(req), .ack_i(ack_b),
        .gnt_o(gnt_b), .gnt_idx_o(idx_b), .gnt_valid_o(val_b));

    function automatic int mdl_pick(input logic [31:0] r, input int nch, input logic [11:0] p);
        for (int l = 0; l < 4; l++) begin
            for (int k = 0; k < 8; k++) begin
                int m;
                int ch;
                m  = (int'(p[l*3 +: 3]) + k) % 8;
                ch = (m / 4) * 16 + l * 4 + (m % 4);
                if (ch < nch && r[ch]) return ch;
            end
        end
        return -1;
    endfunction

    task automatic mdl_next(input logic [31:0] r, input bit ack, input int nch,
                            inout bit v, inout int idx, inout logic [11:0] p);
        int n;
        if (v && ack) begin
            p[((idx % 16) / 4) * 3 +: 3] = 3'((idx / 16) * 4 + (idx % 4) + 1);
        end
        if (!v || ack) begin
            n   = mdl_pick(r, nch, p);
            v   = (n >= 0);
            idx = v ? n : 0;
        end
    endtask

    task automatic chk_one(input string tag, input string name, input bit v, input int idx,
                           input logic vo, input logic [4:0] io, input logic [31:0] go);
        logic [31:0] eg;
        eg = v ? (32'd1 << idx) : 32'd0;
        n_checks++;
        if (vo !== v || int'(io) != idx || go !== eg) begin
            n_fails++;
            $display("FAIL %s %s: valid=%0b idx=%0d gnt=%h, expected valid=%0b idx=%0d gnt=%h",
                     tag, name, vo, io, go, v, idx, eg);
        end
    endtask

    task automatic step(input logic [31:0] r, input bit a, input bit b, input string tag);
        req   = r;
        ack_a = a;
        ack_b = b;
        mdl_next(r, a, 32, mv_a, mi_a, mp_a);
        mdl_next(r, b, 20, mv_b, mi_b, mp_b);
        @(negedge clk);
        chk_one(tag, "full", mv_a, mi_a, val_a, idx_a, gnt_a);
        chk_one(tag, "n20",  mv_b, mi_b, val_b, idx_b, gnt_b);
    endtask

    task automatic expect_idx(input string tag, input bit v, input int idx);
        n_checks++;
        if (val_a !== v || (v && int'(idx_a) != idx)) begin
            n_fails++;
            $display("FAIL %s direct: valid=%0b idx=%0d, expected valid=%0b idx=%0d",
                     tag, val_a, idx_a, v, idx);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        int rr_exp [9] = '{1, 2, 3, 16, 17, 18, 19, 0, 1};
        void'($urandom(32'd2718));
        repeat (3) @(negedge clk);
        // R1: reset state
        chk_one("R1", "full", 0, 0, val_a, idx_a, gnt_a);
        chk_one("R1", "n20",  0, 0, val_b, idx_b, gnt_b);
        rst_n = 1'b1;
        step(32'h0, 0, 0, "R1");
        step(32'h0, 0, 0, "R2");
        expect_idx("R2", 0, 0);
        // R3/R4: upper-group level 0 beats level 3
        step(32'h8001_0000, 0, 0, "R3");
        expect_idx("R3", 1, 16);
        // R7: hold while new urgent request appears
        step(32'h0000_0001, 0, 0, "R7");
        expect_idx("R7", 1, 16);
        // R10: accept and fresh pick in the same edge
        step(32'h0000_0001, 1, 1, "R10");
        expect_idx("R10", 1, 0);
        step(32'h0, 1, 1, "R2");
        expect_idx("R2", 0, 0);
        // R11: accept while idle ignored, R5: rotation through both groups
        for (int i = 0; i < 9; i++) begin
            step(32'h000F_000F, 1, 1, "R5");
            expect_idx("R5", 1, rr_exp[i]);
        end
        // R6: no accept, no movement
        step(32'h000F_000F, 0, 0, "R6");
        step(32'h000F_000F, 0, 0, "R6");
        expect_idx("R6", 1, 1);
        step(32'h0, 1, 1, "R11");
        step(32'h0, 1, 1, "R11");
        // R4: channel 19 (level 0) beats channel 4 (level 1)
        step(32'h0008_0010, 0, 0, "R4");
        expect_idx("R4", 1, 19);
        step(32'h0, 1, 1, "R4");
        // R8: channel 25 only exists on the full instance
        step(32'h0200_0000, 0, 0, "R8");
        expect_idx("R8", 1, 25);
        n_checks++;
        if (val_b !== 1'b0) begin
            n_fails++;
            $display("FAIL R8 n20: valid=%0b, expected 0", val_b);
        end
        step(32'h0, 1, 1, "R8");
        // random mix, R9 consistency covered by the model compare
        for (int i = 0; i < 4000; i++) begin
            logic [31:0] r;
            r = $urandom;
            if (i % 3 == 0) r = r & $urandom & $urandom;
            if (i % 17 == 0) r = '0;
            step(r, 1'($urandom), 1'($urandom), "R9");
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule